// File: doc/BRIEF.md
# Legacy Window Memory Attribute Decoder

This block decides, for every access in a 20-bit physical address space, whether the access is served by system DRAM or is forwarded to the downstream legacy bus. Addresses below 0xA0000 always go to DRAM. The video window 0xA0000–0xBFFFF and the expansion/boot area 0xC0000–0xFFFFF are steered by a small set of programmable attribute bytes and by a system-management-mode input.

The boot area is split into twelve 16 KB segments (0xC0000–0xEFFFF) plus one 64 KB top segment (0xF0000–0xFFFFF). Each segment has a 2-bit attribute, and a read and a write to the same segment can go to different targets. The video window is backed by DRAM only while management mode is active with the management-open bit set, or whenever the force-open bit is set. The attribute bytes are loaded through a byte-wide configuration write port. The steering output is combinational from the access inputs and the stored bytes.

Top module: `legacy_window_decoder`

## Requirements
- R1: Any access with address below 0xA0000 drives `to_dram` high (1 = DRAM, 0 = legacy bus), whatever the direction, mode input or register contents.
- R2: After reset, attribute bytes at offsets 0x59–0x5F read as 0x00 and the management control byte at 0x72 reads as 0x02, so every access in 0xA0000–0xFFFFF targets the bus.
- R3: A 2-bit attribute steers reads by bit 0 and writes by bit 1, with 1 meaning DRAM: 00 sends both to the bus, 01 sends reads to DRAM, 10 sends writes to DRAM, 11 sends both to DRAM.
- R4: Accesses in 0xF0000–0xFFFFF use bits 5:4 of the byte at offset 0x59. The other bits of that byte have no effect.
- R5: Segment i (0..11) covers 0xC0000 + 0x4000·i up to the next segment. It uses the byte at offset 0x5A + (i >> 1): bits 1:0 when i is even and bits 5:4 when i is odd.
- R6: An access in 0xA0000–0xBFFFF targets DRAM when `smm_active` is high and bit 3 of byte 0x72 is set. Otherwise it targets the bus, unless R7 applies.
- R7: When bit 6 of byte 0x72 is set, the video window targets DRAM regardless of `smm_active`.
- R8: Configuration writes to offsets other than 0x59–0x5F and 0x72 change no decode result.
- R9: A configuration write sampled on a rising clock edge changes the decode from that edge onward. The decode otherwise follows address, direction and mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | Access direction, 1 = write |
| smm_active | input | 1 | System management mode active |
| to_dram | output | 1 | 1 = DRAM target, 0 = legacy bus |

## Verification
The hardest case to reach from the ports is an odd segment whose high nibble differs from its even neighbour's low nibble in the same byte, read and written in turn. A byte packing or lane selection error only shows up there. The stimulus loads each attribute byte with a pattern whose two nibbles carry different codes. It then sweeps the first and last address of all twelve segments in both directions, and changes the byte values between passes so that every code appears in every segment. Video-window cases cross both control bits with the mode input. Writes to neighbouring offsets are checked against a sweep that must not change.

// File: rtl/legacy_window_pkg.sv
package legacy_window_pkg;
   localparam int ADDR_W = 20;
   localparam int CFG_AW = 8;
   typedef logic [1:0] attr_t;
   typedef enum logic {TGT_BUS = 1'b0, TGT_DRAM = 1'b1} tgt_e;
   localparam logic [ADDR_W-1:0] VIDEO_LO = 20'hA0000;
   localparam logic [ADDR_W-1:0] BOOT_LO  = 20'hC0000;
   localparam logic [ADDR_W-1:0] TOP_LO   = 20'hF0000;
endpackage

// File: rtl/lw_attr_regs.sv
module lw_attr_regs
   import legacy_window_pkg::*;
#(
   parameter int                ATTR_BYTES = 7,
   parameter logic [CFG_AW-1:0] ATTR_BASE  = 8'h59,
   parameter logic [CFG_AW-1:0] CTRL_OFS   = 8'h72,
   parameter logic [7:0]        CTRL_RST   = 8'h02
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [CFG_AW-1:0]       cfg_addr,
   input  logic [7:0]              cfg_wdata,
   output logic [ATTR_BYTES*8-1:0] attr_bytes,
   output logic [7:0]              ctrl_q
);
   for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_byte
      localparam logic [CFG_AW-1:0] OFS = ATTR_BASE + CFG_AW'(b);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= 8'h00;
         else if (cfg_we && cfg_addr == OFS)  q <= cfg_wdata;
      end
      assign attr_bytes[8*b +: 8] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ctrl_q <= CTRL_RST;
      else if (cfg_we && cfg_addr == CTRL_OFS)  ctrl_q <= cfg_wdata;
   end
endmodule

// File: rtl/lw_seg_select.sv
module lw_seg_select
   import legacy_window_pkg::*;
#(
   parameter int ATTR_BYTES = 7,
   parameter int NUM_SEG    = 12,
   parameter int SEG_SHIFT  = 14
) (
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [ATTR_BYTES*8-1:0] attr_bytes,
   output attr_t                   seg_attr,
   output attr_t                   top_attr
);
   localparam int IDX_W = $clog2(NUM_SEG);

   if (NUM_SEG > 2 * (ATTR_BYTES - 1)) begin : g_bad_cfg
      $error("lw_seg_select: not enough attribute bytes for NUM_SEG");
   end

   attr_t seg_tab [NUM_SEG];
   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      // byte 1 + i/2 of the block, nibble chosen by i parity
      assign seg_tab[i] = attr_bytes[8*(1 + i/2) + 4*(i%2) +: 2];
   end

   logic [IDX_W-1:0] idx;
   logic [ADDR_W-1:0] rel;
   assign rel = acc_addr - BOOT_LO;
   assign idx = rel[SEG_SHIFT +: IDX_W];

   always_comb begin
      seg_attr = 2'b00;
      if (int'(idx) < NUM_SEG) seg_attr = seg_tab[idx];
   end

   assign top_attr = attr_bytes[5:4];
endmodule

// File: rtl/lw_steer.sv
module lw_steer
   import legacy_window_pkg::*;
(
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              smm_active,
   input  logic [7:0]        ctrl_q,
   input  attr_t             seg_attr,
   input  attr_t             top_attr,
   output logic              to_dram
);
   localparam int BIT_SMM_OPEN   = 3;
   localparam int BIT_FORCE_OPEN = 6;

   attr_t a_sel;
   tgt_e  tgt;

   always_comb begin
      a_sel = (acc_addr >= TOP_LO) ? top_attr : seg_attr;
      if (acc_addr < VIDEO_LO)
         tgt = TGT_DRAM;
      else if (acc_addr < BOOT_LO)
         tgt = ((smm_active && ctrl_q[BIT_SMM_OPEN]) || ctrl_q[BIT_FORCE_OPEN])
               ? TGT_DRAM : TGT_BUS;
      else
         tgt = (acc_write ? a_sel[1] : a_sel[0]) ? TGT_DRAM : TGT_BUS;
   end

   assign to_dram = (tgt == TGT_DRAM);
endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
   import legacy_window_pkg::*;
#(
   parameter int                ATTR_BYTES = 7,
   parameter int                NUM_SEG    = 12,
   parameter int                SEG_SHIFT  = 14,
   parameter logic [CFG_AW-1:0] ATTR_BASE  = 8'h59,
   parameter logic [CFG_AW-1:0] CTRL_OFS   = 8'h72,
   parameter logic [7:0]        CTRL_RST   = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              smm_active,
   output logic              to_dram
);
   if ((NUM_SEG << SEG_SHIFT) != int'(TOP_LO - BOOT_LO)) begin : g_bad_geom
      $error("legacy_window_decoder: segments do not tile the boot area");
   end

   logic [ATTR_BYTES*8-1:0] attr_bytes;
   logic [7:0]              ctrl_q;
   attr_t                   seg_attr, top_attr;

   lw_attr_regs #(.ATTR_BYTES(ATTR_BYTES), .ATTR_BASE(ATTR_BASE),
                  .CTRL_OFS(CTRL_OFS), .CTRL_RST(CTRL_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .attr_bytes(attr_bytes), .ctrl_q(ctrl_q));

   lw_seg_select #(.ATTR_BYTES(ATTR_BYTES), .NUM_SEG(NUM_SEG),
                   .SEG_SHIFT(SEG_SHIFT)) u_sel (
      .acc_addr(acc_addr), .attr_bytes(attr_bytes),
      .seg_attr(seg_attr), .top_attr(top_attr));

   lw_steer u_steer (
      .acc_addr(acc_addr), .acc_write(acc_write), .smm_active(smm_active),
      .ctrl_q(ctrl_q), .seg_attr(seg_attr), .top_attr(top_attr),
      .to_dram(to_dram));
endmodule

// File: rtl/lw_checker.sv
module lw_checker
   import legacy_window_pkg::*;
#(
   parameter logic [CFG_AW-1:0] ATTR_BASE = 8'h59,
   parameter logic [CFG_AW-1:0] CTRL_OFS  = 8'h72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [7:0]        cfg_wdata,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_write,
   input logic              smm_active,
   input logic              to_dram
);
   logic in_video;
   assign in_video = (acc_addr >= VIDEO_LO) && (acc_addr < BOOT_LO);

   p_below_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr < VIDEO_LO) |-> to_dram);

   p_reset_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && acc_addr >= BOOT_LO) |-> !to_dram);

   p_top_attr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && $past(cfg_addr) == ATTR_BASE &&
       $past(cfg_wdata[5:4]) == 2'b11 && acc_addr >= TOP_LO) |-> to_dram);

   p_smm_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && $past(cfg_addr) == CTRL_OFS &&
       $past(cfg_wdata) == 8'h00 && in_video) |-> !to_dram);

   p_force_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && $past(cfg_addr) == CTRL_OFS &&
       $past(cfg_wdata[6]) && in_video) |-> to_dram);
endmodule

bind legacy_window_decoder lw_checker #(.ATTR_BASE(ATTR_BASE), .CTRL_OFS(CTRL_OFS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
   .smm_active(smm_active), .to_dram(to_dram));

// File: tb/tb_legacy_window_decoder.sv
module tb_legacy_window_decoder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [19:0] acc_addr = 20'h0;
   logic acc_write = 1'b0;
   logic smm_active = 1'b0;
   logic to_dram;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // behavioural reference: a full 256-byte configuration space
   logic [7:0] cfg_mem [256];

   always #4 clk = ~clk;

   legacy_window_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
      .smm_active(smm_active), .to_dram(to_dram));

   function automatic bit model(int a, bit w, bit s);
      int code;
      int seg;
      logic [7:0] b;
      if (a < 'hA0000) return 1'b1;
      if (a < 'hC0000) return (s && cfg_mem[8'h72][3]) || cfg_mem[8'h72][6];
      if (a >= 'hF0000) code = (cfg_mem[8'h59] >> 4) & 3;
      else begin
         seg = (a - 'hC0000) / 'h4000;
         b = cfg_mem[8'h5A + seg / 2];
         code = (seg % 2 == 1) ? ((b >> 4) & 3) : (b & 3);
      end
      return w ? code[1] : code[0];
   endfunction

   // one clock: drive, compare at negedge, commit model write at posedge
   task automatic cyc(bit we, int ca, int cd, int a, bit w, bit s, string tag);
      bit exp;
      cfg_we = we; cfg_addr = 8'(ca); cfg_wdata = 8'(cd);
      acc_addr = 20'(a); acc_write = w; smm_active = s;
      @(negedge clk);
      exp = model(a, w, s);
      checks++;
      if (to_dram !== exp) begin
         errors++;
         $display("FAIL %s addr=%05h wr=%0b smm=%0b actual=%0b expected=%0b",
                  tag, a, w, s, to_dram, exp);
      end
      @(posedge clk);
      if (we) cfg_mem[ca] = 8'(cd);
      #1;
   endtask

   task automatic acc(int a, bit w, bit s, string tag);
      cyc(1'b0, 0, 0, a, w, s, tag);
   endtask

   task automatic wr_cfg(int ca, int cd, string tag);
      cyc(1'b1, ca, cd, 'hF8000, 1'b0, 1'b0, tag);
   endtask

   task automatic sweep_boot(string tag);
      for (int i = 0; i < 12; i++) begin
         for (int d = 0; d < 2; d++) begin
            acc('hC0000 + 'h4000 * i, d[0], 1'b0, tag);
            acc('hC0000 + 'h4000 * i + 'h3FFF, d[0], 1'b1, tag);
         end
      end
      for (int d = 0; d < 2; d++) begin
         acc('hF0000, d[0], 1'b0, tag);
         acc('hFFFFF, d[0], 1'b0, tag);
      end
   endtask

   task automatic sweep_video(string tag);
      for (int s = 0; s < 2; s++) begin
         for (int d = 0; d < 2; d++) begin
            acc('hA0000, d[0], s[0], tag);
            acc('hBFFFF, d[0], s[0], tag);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) cfg_mem[i] = 8'h00;
      cfg_mem[8'h72] = 8'h02;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R2: reset values, whole window on the bus
      sweep_boot("R2");
      sweep_video("R2");

      // R1: below the window
      acc('h00000, 1'b0, 1'b0, "R1");
      acc('h9FFFF, 1'b1, 1'b1, "R1");
      acc('h5A5A5, 1'b1, 1'b0, "R1");

      // R3, R5: distinct nibble codes per byte, then rotate
      for (int pass = 0; pass < 4; pass++) begin
         for (int b = 0; b < 6; b++)
            wr_cfg('h5A + b, (((b + pass + 1) % 4) << 4) | ((b + pass) % 4), "R5");
         wr_cfg('h59, (((pass + 2) % 4) << 4) | 'hF - (pass % 4), "R4");
         sweep_boot("R3");
      end

      // R4: only bits 5:4 of 0x59
      wr_cfg('h59, 'hCF, "R4");
      sweep_boot("R4");
      wr_cfg('h59, 'h30, "R4");
      sweep_boot("R4");

      // R6, R7: video window control bits against the mode input
      wr_cfg('h72, 'h08, "R6"); sweep_video("R6");
      wr_cfg('h72, 'h00, "R6"); sweep_video("R6");
      wr_cfg('h72, 'hB7, "R6"); sweep_video("R6");
      wr_cfg('h72, 'h40, "R7"); sweep_video("R7");
      wr_cfg('h72, 'h48, "R7"); sweep_video("R7");
      wr_cfg('h72, 'h02, "R7"); sweep_video("R7");

      // R8: neighbouring offsets have no effect
      wr_cfg('h58, 'hFF, "R8");
      wr_cfg('h60, 'hFF, "R8");
      wr_cfg('h71, 'hFF, "R8");
      wr_cfg('h73, 'hFF, "R8");
      wr_cfg('hD9, 'hFF, "R8");
      wr_cfg('hF2, 'hFF, "R8");
      sweep_boot("R8");
      sweep_video("R8");

      // R9: the write cycle itself still sees the old value, next cycle the new
      cyc(1'b1, 'h59, 'h30, 'hF4000, 1'b0, 1'b0, "R9");
      acc('hF4000, 1'b0, 1'b0, "R9");
      cyc(1'b1, 'h59, 'h00, 'hF4000, 1'b1, 1'b0, "R9");
      acc('hF4000, 1'b1, 1'b0, "R9");
      cyc(1'b1, 'h72, 'h40, 'hA8000, 1'b0, 1'b0, "R9");
      acc('hA8000, 1'b0, 1'b0, "R9");

      // R2: a second reset restores defaults
      rst_n = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) cfg_mem[i] = 8'h00;
      cfg_mem[8'h72] = 8'h02;
      sweep_boot("R2");
      sweep_video("R2");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule